// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block carries out single clause-22 management transactions toward an external PHY. A host writes one 32-bit command word that holds a PHY address, a register address, a request bit for a write or for a read, and the data for a write. The block then produces the management clock and shifts the serial frame out on the data line. During the part of a read frame that the PHY drives, it releases the line and collects the returned bits.

The same word is read back at any time. While a frame runs, the request bit that started it reads as 1. When a read finishes, a completion flag is set and the 16 returned bits appear in the low half of the word. The clock half-period, in system clocks, and the preamble length are parameters. The master changes the data line only while the management clock is low, and it samples the line on the clock's rising edge.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `mdio_o` is high and `cmd_rdata` reads 0.
- R2: Command word layout: bits 15:0 hold data, bits 20:16 the register address, bits 25:21 the PHY address, bit 26 the write request, bit 27 the read request and bit 28 the done flag. Bits 31:29 read 0. The request bit of a running frame reads back 1 until the frame ends.
- R3: While a frame runs, each bit lasts 2*HALF_PER clocks: `mdc` is low for the first HALF_PER clocks and high for the last HALF_PER. `mdc` is low when idle.
- R4: Every frame begins with PREAMBLE (default 35) bits of 1, followed by the start bits 0 then 1.
- R5: The opcode follows the start bits: 0,1 for a write and 1,0 for a read. Then come the 5-bit PHY address and the 5-bit register address, each MSB first.
- R6: A write frame then sends turnaround bits 1,0 and the 16 data bits MSB first. It is PREAMBLE+32 bits long, and `mdio_oe` stays high for the whole frame.
- R7: A read frame drives `mdio_oe` low from bit index PREAMBLE+14 (one turnaround bit) to its end, and is PREAMBLE+31 bits long. It samples `mdio_i` on the clock edge at which `mdc` rises, for bits PREAMBLE+15 onward, assembling 16 bits MSB first.
- R8: At the end of a read, the done flag becomes 1 and bits 15:0 hold the captured data. After a write, done stays 0 and bits 15:0 keep the write data.
- R9: A command written while a frame runs is ignored: the readback fields and the frame in progress do not change.
- R10: A command accepted while idle clears the done flag and loads the address and data fields. If neither request bit is set, no frame starts.
- R11: A command with both request bits set performs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
A wrong bit counter or shift register shows up within one bit period, as a misplaced field value or a misplaced `mdio_oe` release. The reference model compares `mdc`, `mdio_o`, `mdio_oe` and the full readback word every clock. A wrong capture position or capture edge corrupts the 16 returned bits, which is visible on the port the moment the read frame ends. This is exercised with patterns that have distinct halves as well as all-zero and all-one returns. A lost ignore rule or a done flag that fails to clear changes the readback word on the cycle after the offending command.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int HDR_BITS = 14;   // start(2) + op(2) + phy(5) + reg(5)

   typedef struct packed {
      logic [2:0]        rsvd;
      logic              done;
      logic              rd_req;
      logic              wr_req;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } cmd_word_t;
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
   parameter int HALF_PER = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise,
   output logic bit_end
);
   localparam int PER = 2 * HALF_PER;
   localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

   logic [CW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                        tcnt <= '0;
      else if (!run)                     tcnt <= '0;
      else if (tcnt == CW'(PER - 1))     tcnt <= '0;
      else                               tcnt <= tcnt + 1'b1;
   end

   assign mdc     = run && (tcnt >= CW'(HALF_PER));
   assign rise    = run && (tcnt == CW'(HALF_PER - 1));
   assign bit_end = run && (tcnt == CW'(PER - 1));

   // R3: the clock goes high on the cycle after a rising-edge marker
   p_rise_mdc_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> mdc);
   // R3: the clock is low after every bit boundary
   p_end_low_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |=> !mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_cmd_pkg::*;
#(
   parameter int PREAMBLE = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              rd,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] regad,
   input  logic [DATA_W-1:0] wdata,
   output logic              bit_o
);
   localparam int FL = PREAMBLE + HDR_BITS + 2 + DATA_W;

   logic [FL-1:0]           shreg;
   logic [FL-1:0]           image;
   logic [1:0]              op_bits;
   logic [DATA_W+1:0]       tail;

   always_comb begin
      op_bits = rd ? 2'b10 : 2'b01;
      tail    = rd ? {(DATA_W + 2){1'b1}} : {2'b10, wdata};
      image   = {{PREAMBLE{1'b1}}, 2'b01, op_bits, phy, regad, tail};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     shreg <= '1;
      else if (load)  shreg <= image;
      else if (shift) shreg <= {shreg[FL-2:0], 1'b1};
   end

   assign bit_o = shreg[FL-1];

   // R5: each bit boundary advances the serial stream by exactly one place
   p_shift_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (bit_o == $past(shreg[FL-2])));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
   import mdio_cmd_pkg::*;
#(
   parameter int HALF_PER = 4,
   parameter int PREAMBLE = 35
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_we,
   input  logic [31:0] cmd_wdata,
   output logic [31:0] cmd_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int LEN_WR  = PREAMBLE + HDR_BITS + 2 + DATA_W;
   localparam int LEN_RD  = PREAMBLE + HDR_BITS + 1 + DATA_W;
   localparam int TA_IDX  = PREAMBLE + HDR_BITS;
   localparam int CAP_IDX = TA_IDX + 1;
   localparam int BW      = $clog2(LEN_WR + 1);

   generate
      if (HALF_PER < 1) begin : g_bad_half
         $error("HALF_PER must be at least 1");
      end
      if (PREAMBLE < 1) begin : g_bad_pre
         $error("PREAMBLE must be at least 1");
      end
   endgenerate

   cmd_word_t         cin;
   cmd_word_t         cout;
   logic              busy, rd_q, done_q;
   logic [ADDR_W-1:0] phy_q, regad_q;
   logic [DATA_W-1:0] data_q, cap;
   logic [BW-1:0]     bidx;
   logic              accept, start, rise, bit_end, last_bit;

   assign cin      = cmd_word_t'(cmd_wdata);
   assign accept   = cmd_we && !busy;
   assign start    = accept && (cin.rd_req || cin.wr_req);
   assign last_bit = bit_end && (bidx == (rd_q ? BW'(LEN_RD - 1) : BW'(LEN_WR - 1)));

   mdio_bit_timer #(.HALF_PER(HALF_PER)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mdc(mdc), .rise(rise), .bit_end(bit_end)
   );

   mdio_frame_shifter #(.PREAMBLE(PREAMBLE)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .shift(bit_end),
      .rd(cin.rd_req), .phy(cin.phy), .regad(cin.regad), .wdata(cin.data),
      .bit_o(mdio_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rd_q    <= 1'b0;
         done_q  <= 1'b0;
         phy_q   <= '0;
         regad_q <= '0;
         data_q  <= '0;
         cap     <= '0;
         bidx    <= '0;
      end else if (accept) begin
         phy_q   <= cin.phy;
         regad_q <= cin.regad;
         data_q  <= cin.data;
         done_q  <= 1'b0;
         busy    <= start;
         rd_q    <= cin.rd_req;
         bidx    <= '0;
      end else if (busy) begin
         if (rise && rd_q && (bidx >= BW'(CAP_IDX)))
            cap <= {cap[DATA_W-2:0], mdio_i};
         if (last_bit) begin
            busy <= 1'b0;
            if (rd_q) begin
               done_q <= 1'b1;
               data_q <= cap;
            end
         end else if (bit_end) begin
            bidx <= bidx + 1'b1;
         end
      end
   end

   always_comb begin
      cout        = '0;
      cout.done   = done_q;
      cout.rd_req = busy && rd_q;
      cout.wr_req = busy && !rd_q;
      cout.phy    = phy_q;
      cout.regad  = regad_q;
      cout.data   = data_q;
   end

   assign cmd_rdata = cout;
   assign mdio_oe   = busy && (!rd_q || (bidx < BW'(TA_IDX)));

   // R9: a command arriving mid-frame leaves the address fields untouched
   p_ignore_busy_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> ($stable(phy_q) && $stable(regad_q)));
   // R10: an accepted command clears the done flag
   p_done_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_we) |=> !cmd_rdata[28]);
   // R8: the end of a read frame raises done and frees the block
   p_done_read_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && rd_q) |=> (cmd_rdata[28] && !busy));
endmodule

// File: tb/mdio_cmd_master_tb.sv
module mdio_cmd_master_tb;
   localparam int H   = 4;
   localparam int PRE = 35;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #4 clk = ~clk;

   mdio_cmd_master #(.HALF_PER(H), .PREAMBLE(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   // reference model state
   bit          m_busy, m_rd, m_done;
   int          m_t, m_len;
   logic [4:0]  m_phy, m_reg;
   logic [15:0] m_data, m_cap;
   logic [15:0] phy_val = 16'h0000;
   bit          q[$];
   int          vectors = 0, miscompares = 0, cycles = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic build(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
      q.delete();
      for (int i = 0; i < PRE; i++) q.push_back(1'b1);
      q.push_back(1'b0); q.push_back(1'b1);
      if (rd) begin q.push_back(1'b1); q.push_back(1'b0); end
      else    begin q.push_back(1'b0); q.push_back(1'b1); end
      for (int i = 4; i >= 0; i--) q.push_back(phy[i]);
      for (int i = 4; i >= 0; i--) q.push_back(rg[i]);
      if (rd) begin
         for (int i = 0; i < 17; i++) q.push_back(1'b1);
         m_len = PRE + 31;
      end else begin
         q.push_back(1'b1); q.push_back(1'b0);
         for (int i = 15; i >= 0; i--) q.push_back(d[i]);
         m_len = PRE + 32;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_rd = 0; m_done = 0; m_t = 0;
         m_phy = '0; m_reg = '0; m_data = '0; m_cap = '0;
      end else if (m_busy) begin
         int b, ph;
         b  = m_t / (2 * H);
         ph = m_t % (2 * H);
         if (ph == H - 1 && m_rd && b >= PRE + 15) m_cap = {m_cap[14:0], mdio_i};
         if (ph == 2 * H - 1 && b == m_len - 1) begin
            m_busy = 0;
            if (m_rd) begin m_done = 1; m_data = m_cap; end
         end else m_t++;
      end else if (cmd_we) begin
         m_done = 0;
         m_phy  = cmd_wdata[25:21];
         m_reg  = cmd_wdata[20:16];
         m_data = cmd_wdata[15:0];
         if (cmd_wdata[27] || cmd_wdata[26]) begin
            m_busy = 1; m_t = 0; m_rd = cmd_wdata[27];
            build(m_rd, m_phy, m_reg, m_data);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int b, ph;
         logic e_mdc, e_oe, e_o;
         b  = m_t / (2 * H);
         ph = m_t % (2 * H);
         e_mdc = m_busy && (ph >= H);
         e_oe  = m_busy && (!m_rd || b < PRE + 14);
         e_o   = m_busy ? q[b] : 1'b1;
         chk("R3 mdc", {31'b0, mdc}, {31'b0, e_mdc});
         chk(m_rd ? "R7 mdio_oe" : "R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
         chk(b < PRE + 2 ? "R4 mdio_o" : (b < PRE + 14 ? "R5 mdio_o" : "R6 mdio_o"),
             {31'b0, mdio_o}, {31'b0, e_o});
         chk("R2 readback", cmd_rdata,
             {3'b0, m_done, m_busy && m_rd, m_busy && !m_rd, m_phy, m_reg, m_data});
         if (m_busy && m_rd && b >= PRE + 15) mdio_i = phy_val[15 - (b - PRE - 15)];
         else mdio_i = 1'b1;
      end
   end

   task automatic issue(logic [31:0] w);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] word(bit rd, bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
      return {4'b0, rd, wr, p, r, d};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", cmd_rdata, 32'h0);
      chk("R1 mdc", {31'b0, mdc}, 32'h0);
      chk("R1 oe", {31'b0, mdio_oe}, 32'h0);
      chk("R1 mdio_o", {31'b0, mdio_o}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 write frame
      issue(word(0, 1, 5'd5, 5'h11, 16'hA5C3));
      repeat (100) @(negedge clk);
      chk("R2 wr pending", {31'b0, cmd_rdata[26]}, 32'h1);
      // R9 command while busy ignored
      issue(word(1, 0, 5'd1, 5'd2, 16'h0BAD));
      chk("R9 phy kept", {27'b0, cmd_rdata[25:21]}, 32'd5);
      chk("R9 data kept", {16'b0, cmd_rdata[15:0]}, 32'hA5C3);
      wait_idle();
      chk("R8 write no done", {31'b0, cmd_rdata[28]}, 32'h0);
      chk("R8 write data kept", {16'b0, cmd_rdata[15:0]}, 32'hA5C3);

      // R7 read frame
      phy_val = 16'hBEEF;
      issue(word(1, 0, 5'h1F, 5'h00, 16'h0000));
      wait_idle();
      chk("R8 read done", {31'b0, cmd_rdata[28]}, 32'h1);
      chk("R7 read data", {16'b0, cmd_rdata[15:0]}, 32'hBEEF);

      // R10 no-request command clears done, starts nothing
      issue(word(0, 0, 5'd3, 5'd2, 16'h1234));
      chk("R10 done cleared", {31'b0, cmd_rdata[28]}, 32'h0);
      repeat (20) begin
         @(negedge clk);
         chk("R10 no frame mdc", {30'b0, mdc, mdio_oe}, 32'h0);
      end
      chk("R10 fields", cmd_rdata, word(0, 0, 5'd3, 5'd2, 16'h1234));

      // R11 both requests set -> read
      phy_val = 16'h8001;
      issue(word(1, 1, 5'h0A, 5'h15, 16'h7777));
      chk("R11 read pending", {30'b0, cmd_rdata[27:26]}, 32'h2);
      wait_idle();
      chk("R11 read data", {16'b0, cmd_rdata[15:0]}, 32'h8001);

      // R7 edge patterns
      phy_val = 16'hFFFF;
      issue(word(1, 0, 5'h15, 5'h0A, 16'h0));
      wait_idle();
      chk("R7 ones", {16'b0, cmd_rdata[15:0]}, 32'hFFFF);
      phy_val = 16'h0000;
      issue(word(1, 0, 5'h00, 5'h1F, 16'h0));
      wait_idle();
      chk("R7 zeros", {16'b0, cmd_rdata[15:0]}, 32'h0000);
      // R10 new command after a read clears done
      issue(word(0, 1, 5'h00, 5'h00, 16'hFFFF));
      chk("R10 done cleared again", {31'b0, cmd_rdata[28]}, 32'h0);
      wait_idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(8 * 20000);
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule